// File: doc/BRIEF.md
# Interrupt request register bank

This block gathers up to thirty-two hardware interrupt lines and a software-owned interrupt register, and turns them into the masked request vector that a downstream prioritiser or processor interface consumes. Each channel's request is the hardware line ORed with its software bit, gated by that channel's enable bit, and registered before it leaves the block. A one-bit summary output reports whether any masked request is pending.

Software reaches the block through a simple word-addressed read/write slave port. The port exposes the unmasked hardware lines and the software register, which can be written whole or through write-one-to-set and write-one-to-clear aliases. The enable mask has the same kind of aliases. The port also carries a global configuration word, a status word and an aligned vector table base. The parameter `NUM_IRQ` sets how many channels exist. Every bit above that count is tied off: it reads zero, ignores writes and never raises a request.

Top module: `irq_regbank`

## Requirements
- R1: After synchronous reset every register reads 0 and both `irq_req` and `any_req` are 0.
- R2: A read of word 36 returns `hw_irq` with bits at and above `NUM_IRQ` forced to 0. Writes to word 36 change nothing.
- R3: `irq_req[i]` equals (`hw_irq[i]` OR software bit i) AND enable bit i, as sampled one clock earlier. It is always 0 for channels at or above `NUM_IRQ`.
- R4: Word 37 is the software interrupt register. It is read/write, and bits at or above `NUM_IRQ` read 0 whatever is written.
- R5: Writing word 38 sets each software bit whose data bit is 1 and leaves the bits written 0 unchanged. Reads of word 38 return 0.
- R6: Writing word 39 clears each software bit whose data bit is 1 and leaves the bits written 0 unchanged. Reads of word 39 return 0.
- R7: Word 33 is the enable mask, read/write. Word 34 sets enable bits and word 35 clears them, following the same write-one rules, and both read as 0. Enable bits at or above `NUM_IRQ` read 0.
- R8: Word 40 holds the configuration. Its low `CFG_W` bits keep what was written, and the higher bits read 0.
- R9: Word 41 is read-only status. Bit 0 is `any_req`. Bit 1 is 1 when any implemented hardware line is high. All other bits are 0.
- R10: Word 42 holds the vector table base. It is read/write, but bits 1:0 always read 0.
- R11: `any_req` is 1 exactly when some bit of `irq_req` is 1.
- R12: Reads of any other word offset return 0, and writes to them have no effect.
- R13: `bus_rdata` is loaded on the clock edge that samples `bus_rd`, and keeps its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 6 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| hw_irq | input | 32 | Hardware interrupt lines, level-sensitive |
| irq_req | output | 32 | Registered masked request vector |
| any_req | output | 1 | OR of all bits of `irq_req` |

## Verification
Two events can land in the same cycle. A hardware line can be high for a channel while software clears that channel's software bit, and an unimplemented hardware line can be high while every enable bit is set. The bench holds hardware line 1 high, clears software bit 1 through word 39, and expects `irq_req[1]` to stay at 1, because the OR is taken before the mask. In the same way it drives line 25 with all enables written and expects that bit to stay 0 in the raw view and in the request vector.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;

    localparam int IRQ_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    typedef enum logic [ADDR_W-1:0] {
        OFS_EN      = 6'd33,
        OFS_EN_SET  = 6'd34,
        OFS_EN_CLR  = 6'd35,
        OFS_RAW     = 6'd36,
        OFS_SWI     = 6'd37,
        OFS_SWI_SET = 6'd38,
        OFS_SWI_CLR = 6'd39,
        OFS_CFG     = 6'd40,
        OFS_STAT    = 6'd41,
        OFS_VTB     = 6'd42
    } reg_ofs_e;

    // One update request for a bank of per-channel bits
    typedef struct packed {
        logic              ld;
        logic [IRQ_W-1:0]  ldval;
        logic [IRQ_W-1:0]  set;
        logic [IRQ_W-1:0]  clr;
    } bit_upd_t;

    typedef struct packed {
        logic [DATA_W-3:0] rsvd;
        logic              raw_any;
        logic              req_any;
    } status_t;

    // Everything the read path can return
    typedef struct packed {
        logic [DATA_W-1:0] raw;
        logic [DATA_W-1:0] swi;
        logic [DATA_W-1:0] en;
        logic [DATA_W-1:0] cfg;
        status_t           status;
        logic [DATA_W-1:0] vtb;
    } rd_src_t;

    localparam logic [DATA_W-1:0] VTB_KEEP = ~(DATA_W'(3));

    function automatic logic [IRQ_W-1:0] impl_mask(input int n);
        logic [IRQ_W-1:0] m;
        for (int i = 0; i < IRQ_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_keep(input int w);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < w);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_bitreg.sv
module irq_bitreg
    import irq_regbank_pkg::*;
#(
    parameter logic [IRQ_W-1:0] KEEP = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  bit_upd_t         upd,
    output logic [IRQ_W-1:0] q
);

    logic [IRQ_W-1:0] nxt;

    // Per channel: a full load wins, else set takes priority over clear.
    // Channels outside KEEP are held at zero.
    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        assign nxt[i] = KEEP[i] &
                        (upd.ld ? upd.ldval[i]
                                : ((q[i] & ~upd.clr[i]) | upd.set[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/irq_decode.sv
module irq_decode
    import irq_regbank_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bit_upd_t          swi_upd,
    output bit_upd_t          en_upd,
    output logic              cfg_we,
    output logic              vtb_we
);

    always_comb begin
        swi_upd = '0;
        en_upd  = '0;
        cfg_we  = 1'b0;
        vtb_we  = 1'b0;
        if (wr) begin
            case (addr)
                OFS_SWI: begin
                    swi_upd.ld    = 1'b1;
                    swi_upd.ldval = wdata;
                end
                OFS_SWI_SET: swi_upd.set = wdata;
                OFS_SWI_CLR: swi_upd.clr = wdata;
                OFS_EN: begin
                    en_upd.ld    = 1'b1;
                    en_upd.ldval = wdata;
                end
                OFS_EN_SET:  en_upd.set = wdata;
                OFS_EN_CLR:  en_upd.clr = wdata;
                OFS_CFG:     cfg_we = 1'b1;
                OFS_VTB:     vtb_we = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_mask.sv
module irq_mask
    import irq_regbank_pkg::*;
#(
    parameter logic [IRQ_W-1:0] KEEP = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] hw,
    input  logic [IRQ_W-1:0] swi,
    input  logic [IRQ_W-1:0] en,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] req_q
);

    logic [IRQ_W-1:0] merged;

    assign raw    = hw & KEEP;
    assign merged = (raw | swi) & en;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= merged & KEEP;
        end
    end

endmodule

// File: rtl/irq_rdmux.sv
module irq_rdmux
    import irq_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  rd_src_t           src,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] sel;

    // Set/clear aliases and unmapped offsets fall to the zero default
    always_comb begin
        case (addr)
            OFS_RAW:  sel = src.raw;
            OFS_SWI:  sel = src.swi;
            OFS_EN:   sel = src.en;
            OFS_CFG:  sel = src.cfg;
            OFS_STAT: sel = src.status;
            OFS_VTB:  sel = src.vtb;
            default:  sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= sel;
        end
    end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irq_regbank_pkg::*;
#(
    parameter int NUM_IRQ = 20,
    parameter int CFG_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IRQ_W-1:0]  hw_irq,
    output logic [IRQ_W-1:0]  irq_req,
    output logic              any_req
);

    localparam logic [IRQ_W-1:0]  IMPL     = impl_mask(NUM_IRQ);
    localparam logic [DATA_W-1:0] CFG_KEEP = cfg_keep(CFG_W);

    bit_upd_t          swi_upd;
    bit_upd_t          en_upd;
    logic              cfg_we;
    logic              vtb_we;
    logic [IRQ_W-1:0]  swi_q;
    logic [IRQ_W-1:0]  en_q;
    logic [IRQ_W-1:0]  raw;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] vtb_q;
    status_t           status;
    rd_src_t           rd_src;

    irq_decode u_decode (
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .swi_upd (swi_upd),
        .en_upd  (en_upd),
        .cfg_we  (cfg_we),
        .vtb_we  (vtb_we)
    );

    irq_bitreg #(.KEEP(IMPL)) u_swi (
        .clk (clk),
        .rst (rst),
        .upd (swi_upd),
        .q   (swi_q)
    );

    irq_bitreg #(.KEEP(IMPL)) u_en (
        .clk (clk),
        .rst (rst),
        .upd (en_upd),
        .q   (en_q)
    );

    irq_mask #(.KEEP(IMPL)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .hw    (hw_irq),
        .swi   (swi_q),
        .en    (en_q),
        .raw   (raw),
        .req_q (irq_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            vtb_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= bus_wdata & CFG_KEEP;
            if (vtb_we) vtb_q <= bus_wdata & VTB_KEEP;
        end
    end

    assign any_req = |irq_req;

    always_comb begin
        status         = '0;
        status.req_any = any_req;
        status.raw_any = |raw;
    end

    assign rd_src = '{raw: raw, swi: swi_q, en: en_q, cfg: cfg_q,
                      status: status, vtb: vtb_q};

    irq_rdmux u_rdmux (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .src   (rd_src),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk
    import irq_regbank_pkg::*;
#(
    parameter int NUM_IRQ = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [IRQ_W-1:0]  hw_irq,
    input logic [IRQ_W-1:0]  irq_req,
    input logic [IRQ_W-1:0]  swi,
    input logic [IRQ_W-1:0]  en,
    input logic [DATA_W-1:0] vtb
);

    localparam logic [IRQ_W-1:0] IMPL = impl_mask(NUM_IRQ);

    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_req == $past((hw_irq | swi) & en & IMPL));        // R3

    AST_BITS_TIED: assert property (@(posedge clk) disable iff (rst)
        ((swi | en) & ~IMPL) == '0);                                    // R4

    AST_SWI_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SWI_SET) |=>
            (swi & $past(bus_wdata & IMPL)) == $past(bus_wdata & IMPL)); // R5

    AST_SWI_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SWI_CLR) |=>
            (swi & $past(bus_wdata)) == '0);                            // R6

    AST_VTB_ALIGN: assert property (@(posedge clk) disable iff (rst)
        vtb[1:0] == 2'b00);                                             // R10

    AST_RAW_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_RAW) |=>
            bus_rdata == $past(hw_irq & IMPL));                         // R2

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));                                // R13

endmodule

bind irq_regbank irq_regbank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_irq    (hw_irq),
    .irq_req   (irq_req),
    .swi       (swi_q),
    .en        (en_q),
    .vtb       (vtb_q)
);

// File: tb/irq_regbank_bench.sv
module irq_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_irq = '0;
    logic [31:0] irq_req;
    logic        any_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_regbank u_irq_regbank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_irq    (hw_irq),
        .irq_req   (irq_req),
        .any_req   (any_req)
    );

    // Default build: NUM_IRQ = 20, CFG_W = 8
    localparam logic [31:0] IMPL = 32'h000F_FFFF;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_check(input string req, input logic [5:0] a,
                              input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        check("R1 irq_req", irq_req, 32'h0);
        check("R1 any_req", {31'h0, any_req}, 32'h0);
        for (int a = 33; a <= 42; a++) begin
            read_check("R1 register", 6'(a), 32'h0);
        end
    endtask

    task automatic t_raw;
        hw_irq = 32'hFFF0_00A5;
        read_check("R2 raw masked to implemented", 6'd36, 32'h0000_00A5);
        bus_write(6'd36, 32'hFFFF_FFFF);
        read_check("R2 raw ignores write", 6'd36, 32'h0000_00A5);
        hw_irq = 32'h0;
        read_check("R2 raw follows lines", 6'd36, 32'h0);
    endtask

    task automatic t_swi;
        bus_write(6'd37, 32'hFFFF_FFFF);
        read_check("R4 swi unimplemented bits", 6'd37, IMPL);
        bus_write(6'd37, 32'h0000_0000);
        read_check("R4 swi cleared by write", 6'd37, 32'h0);
    endtask

    task automatic t_swi_set;
        bus_write(6'd38, 32'h0000_0003);
        read_check("R5 set alias sets", 6'd37, 32'h0000_0003);
        bus_write(6'd38, 32'h0000_0000);
        read_check("R5 zero write no effect", 6'd37, 32'h0000_0003);
        read_check("R5 set alias reads 0", 6'd38, 32'h0);
    endtask

    task automatic t_swi_clr;
        bus_write(6'd39, 32'h0000_0001);
        read_check("R6 clear alias clears", 6'd37, 32'h0000_0002);
        bus_write(6'd39, 32'h0000_0000);
        read_check("R6 zero write no effect", 6'd37, 32'h0000_0002);
        read_check("R6 clear alias reads 0", 6'd39, 32'h0);
        bus_write(6'd39, 32'hFFFF_FFFF);
        read_check("R6 clear all", 6'd37, 32'h0);
    endtask

    task automatic t_enable;
        bus_write(6'd33, 32'hFFFF_FFFF);
        read_check("R7 enable unimplemented bits", 6'd33, IMPL);
        bus_write(6'd33, 32'h0000_00F0);
        read_check("R7 enable write", 6'd33, 32'h0000_00F0);
        bus_write(6'd34, 32'h0000_000F);
        read_check("R7 enable set alias", 6'd33, 32'h0000_00FF);
        bus_write(6'd35, 32'h0000_00F0);
        read_check("R7 enable clear alias", 6'd33, 32'h0000_000F);
        read_check("R7 enable set alias reads 0", 6'd34, 32'h0);
        read_check("R7 enable clear alias reads 0", 6'd35, 32'h0);
    endtask

    task automatic t_request;
        // enable = 0x0F here; software bit 1 plus lines 0 and 2
        hw_irq = 32'h0000_0005;
        bus_write(6'd38, 32'h0000_0002);
        @(negedge clk);
        check("R3 merged request", irq_req, 32'h0000_0007);
        check("R11 any_req high", {31'h0, any_req}, 32'h1);
        read_check("R9 status both", 6'd41, 32'h0000_0003);
        // Same-cycle overlap: line 1 high while software bit 1 is cleared
        hw_irq = 32'h0000_0007;
        bus_write(6'd39, 32'h0000_0002);
        @(negedge clk);
        check("R3 line keeps request after sw clear", irq_req, 32'h0000_0007);
        // Line outside the enable mask
        hw_irq = 32'h0000_0010;
        @(negedge clk);
        check("R3 masked line dropped", irq_req, 32'h0);
        check("R11 any_req low", {31'h0, any_req}, 32'h0);
        read_check("R9 status raw only", 6'd41, 32'h0000_0002);
        bus_write(6'd41, 32'hFFFF_FFFF);
        read_check("R9 status ignores write", 6'd41, 32'h0000_0002);
        // Unimplemented line with all enables written
        hw_irq = 32'h0200_0000;
        bus_write(6'd33, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R3 unimplemented line never requests", irq_req, 32'h0);
        read_check("R2 unimplemented raw bit", 6'd36, 32'h0);
        // Registered: hw rises, output one edge later
        hw_irq = 32'h0008_0000;
        check("R3 not yet registered", irq_req, 32'h0);
        @(negedge clk);
        check("R3 top implemented channel", irq_req, 32'h0008_0000);
        hw_irq = 32'h0;
        bus_write(6'd33, 32'h0);
        @(negedge clk);
        check("R3 idle", irq_req, 32'h0);
    endtask

    task automatic t_cfg_vtb;
        bus_write(6'd40, 32'hABCD_1234);
        read_check("R8 cfg low bits kept", 6'd40, 32'h0000_0034);
        bus_write(6'd42, 32'h1234_5677);
        read_check("R10 vtb aligned", 6'd42, 32'h1234_5674);
    endtask

    task automatic t_unmapped;
        bus_write(6'd0, 32'hFFFF_FFFF);
        bus_write(6'd50, 32'hFFFF_FFFF);
        read_check("R12 unmapped 0", 6'd0, 32'h0);
        read_check("R12 unmapped 50", 6'd50, 32'h0);
        read_check("R12 swi untouched", 6'd37, 32'h0);
    endtask

    task automatic t_rdhold;
        logic [31:0] d;
        bus_read(6'd42, d);
        bus_write(6'd42, 32'h0000_0100);
        repeat (2) @(negedge clk);
        check("R13 rdata held without read", bus_rdata, 32'h1234_5674);
        read_check("R13 new read loads", 6'd42, 32'h0000_0100);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_raw;
        t_swi;
        t_swi_set;
        t_swi_clr;
        t_enable;
        t_request;
        t_cfg_vtb;
        t_unmapped;
        t_rdhold;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule